// File: doc/BRIEF.md
# AUX Request Retry Controller

This block carries one auxiliary-channel request through to a final outcome. It works on top of a lower-level transfer port. When a request is started, the block raises a one-cycle issue strobe. It then waits for the port to report completion, which comes with a transfer error code, a 4-bit reply byte and a returned byte count. The reply is decoded in one of two ways, chosen by a mode input latched at start. In native mode only the native reply field is examined. In I2C-over-AUX mode a native acknowledge is followed by decoding of the I2C reply field.

Busy indications from the port are retried at once. Deferral replies are retried after a wait that is counted with a 1 µs tick enable. The wait is 400 ticks for a native defer in native mode, 500 ticks for a native defer in I2C mode, and 400 ticks for an I2C defer. Every kind of retry draws on one shared cap of seven attempts.

The outcome is reported as a single-cycle done pulse together with a 3-bit status. The byte count is also reported on success.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, `done_o` and `xfer_req_o` are low, and no attempt is made until `start_i` is seen.
- R2: A start in idle produces a one-cycle `xfer_req_o` strobe. A `start_i` asserted while a request is in progress is ignored and does not produce an extra attempt.
- R3: A transfer error code of 01 (busy) causes the next attempt to be issued at once, with no wait.
- R4: A transfer error code of 10 or 11 ends the request with status 5 (transfer error), and no further attempt is made.
- R5: A native reply field (reply bits [1:0]) of 01 ends the request with status 1 (NACK). This holds in both modes.
- R6: In native mode, a native ACK (00) gives status 2 (short) when the returned count is below the requested size. Otherwise it gives status 0 (OK) with `count_o` equal to the returned count. Reply bits [3:2] are ignored in this mode.
- R7: In native mode, a native DEFER (10) waits 400 ticks of `tick_us_i` and then issues a new attempt.
- R8: In I2C mode (`i2c_mode_i`=1), a native DEFER waits 500 ticks and then issues a new attempt.
- R9: A native reply field of 11 ends the request with status 3 (invalid reply), in either mode.
- R10: In I2C mode, a native ACK leads to decoding of the I2C field (reply bits [3:2]). An I2C ACK (00) gives OK when the count is full and status 2 when it is short. An I2C NACK (01) gives status 1.
- R11: In I2C mode, an I2C DEFER (10) waits 400 ticks and then issues a new attempt. An I2C field of 11 gives status 3.
- R12: At most 7 attempts are issued per request. A retry that would need an eighth attempt instead ends the request with status 4 (exhausted).
- R13: Each request ends with exactly one `done_o` pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a request (accepted only when idle) |
| i2c_mode_i | input | 1 | 1 selects I2C-over-AUX decoding, 0 selects native |
| req_size_i | input | SIZE_W | Requested byte count |
| tick_us_i | input | 1 | 1 µs tick enable for defer waits |
| xfer_req_o | output | 1 | One-cycle strobe that issues an attempt |
| xfer_done_i | input | 1 | Transfer port completion strobe |
| xfer_err_i | input | 2 | 00 none, 01 busy, 10/11 failure |
| reply_i | input | 4 | [1:0] native code, [3:2] I2C code; 00 ACK, 01 NACK, 10 DEFER |
| count_i | input | SIZE_W | Byte count returned by the port |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | 0 OK, 1 NACK, 2 short, 3 invalid, 4 exhausted, 5 transfer error |
| count_o | output | SIZE_W | Returned count on OK, else 0 |

## Verification
The bench sweeps every pairing of requested size and returned count from 0 to 7 in both modes. A design that compared the wrong way round, or that let a short count through, would report OK where status 2 is due. It also sweeps the number of leading busy replies from 0 to 8, and runs an all-defer request. A cap that is off by one would show up as six or eight attempts, or as an exhaustion where success is due. The bench counts ticks between a deferral and the next issue strobe, so a wait length taken from the wrong mode, or a wait that starts on busy, stands out. Separate cases decode each reply field in the mode where it must be ignored, and restart the request while it is in flight.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;
  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_NACK      = 3'd1,
    ST_SHORT     = 3'd2,
    ST_INVALID   = 3'd3,
    ST_EXHAUSTED = 3'd4,
    ST_XFER_ERR  = 3'd5
  } status_e;

  typedef enum logic [1:0] {
    ACT_FINISH = 2'd0,
    ACT_RETRY  = 2'd1,
    ACT_WAIT   = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    WSEL_NATIVE     = 2'd0,
    WSEL_I2C_NATIVE = 2'd1,
    WSEL_I2C        = 2'd2
  } wsel_e;

  localparam logic [1:0] CODE_ACK   = 2'b00;
  localparam logic [1:0] CODE_NACK  = 2'b01;
  localparam logic [1:0] CODE_DEFER = 2'b10;

  localparam logic [1:0] XERR_NONE = 2'b00;
  localparam logic [1:0] XERR_BUSY = 2'b01;
endpackage

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_retry_pkg::*;
#(
  parameter int SIZE_W = 5
) (
  input  logic              i2c_mode_i,
  input  logic [1:0]        xfer_err_i,
  input  logic [3:0]        reply_i,
  input  logic [SIZE_W-1:0] count_i,
  input  logic [SIZE_W-1:0] size_i,
  output act_e              act_o,
  output status_e           status_o,
  output wsel_e             wsel_o
);
  logic [1:0] nat_code, i2c_code;
  logic       short_cnt;

  assign nat_code  = reply_i[1:0];
  assign i2c_code  = reply_i[3:2];
  assign short_cnt = count_i < size_i;

  always_comb begin
    act_o    = ACT_FINISH;
    status_o = ST_OK;
    wsel_o   = WSEL_NATIVE;
    if (xfer_err_i == XERR_BUSY) begin
      act_o = ACT_RETRY;
    end else if (xfer_err_i != XERR_NONE) begin
      status_o = ST_XFER_ERR;
    end else begin
      unique case (nat_code)
        CODE_NACK:  status_o = ST_NACK;
        CODE_DEFER: begin
          act_o  = ACT_WAIT;
          wsel_o = i2c_mode_i ? WSEL_I2C_NATIVE : WSEL_NATIVE;
        end
        CODE_ACK: begin
          if (!i2c_mode_i) begin
            status_o = short_cnt ? ST_SHORT : ST_OK;
          end else begin
            unique case (i2c_code)
              CODE_ACK:   status_o = short_cnt ? ST_SHORT : ST_OK;
              CODE_NACK:  status_o = ST_NACK;
              CODE_DEFER: begin
                act_o  = ACT_WAIT;
                wsel_o = WSEL_I2C;
              end
              default:    status_o = ST_INVALID;
            endcase
          end
        end
        default: status_o = ST_INVALID;
      endcase
    end
  end
endmodule

// File: rtl/aux_defer_timer.sv
module aux_defer_timer
  import aux_retry_pkg::*;
#(
  parameter int NAT_US     = 400,
  parameter int I2C_NAT_US = 500,
  parameter int I2C_US     = 400
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  wsel_e sel_i,
  input  logic  tick_i,
  output logic  running_o,
  output logic  expire_o
);
  localparam int MAX_A  = (NAT_US > I2C_NAT_US) ? NAT_US : I2C_NAT_US;
  localparam int MAX_US = (MAX_A > I2C_US) ? MAX_A : I2C_US;
  localparam int CNT_W  = $clog2(MAX_US + 1);

  logic [CNT_W-1:0] cnt_q, len;

  always_comb begin
    unique case (sel_i)
      WSEL_I2C_NATIVE: len = CNT_W'(I2C_NAT_US);
      WSEL_I2C:        len = CNT_W'(I2C_US);
      default:         len = CNT_W'(NAT_US);
    endcase
  end

  assign running_o = cnt_q != '0;
  assign expire_o  = running_o && tick_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= len;
    else if (running_o && tick_i) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/aux_attempt_ctr.sv
module aux_attempt_ctr #(
  parameter int MAX_TRIES = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] cnt_q;

  assign last_o = cnt_q >= CW'(MAX_TRIES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int SIZE_W     = 5,
  parameter int MAX_TRIES  = 7,
  parameter int NAT_US     = 400,
  parameter int I2C_NAT_US = 500,
  parameter int I2C_US     = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              i2c_mode_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              tick_us_i,
  output logic              xfer_req_o,
  input  logic              xfer_done_i,
  input  logic [1:0]        xfer_err_i,
  input  logic [3:0]        reply_i,
  input  logic [SIZE_W-1:0] count_i,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic [SIZE_W-1:0] count_o
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP, S_WAIT} state_e;

  state_e            state_q;
  logic              mode_q;
  logic [SIZE_W-1:0] size_q;
  logic              done_q;
  status_e           status_q;
  logic [SIZE_W-1:0] count_q;

  act_e    dec_act;
  status_e dec_status;
  wsel_e   dec_wsel;
  logic    last_try, wait_run, wait_exp, wait_load, active;

  aux_reply_decode #(.SIZE_W(SIZE_W)) u_dec (
    .i2c_mode_i (mode_q),
    .xfer_err_i (xfer_err_i),
    .reply_i    (reply_i),
    .count_i    (count_i),
    .size_i     (size_q),
    .act_o      (dec_act),
    .status_o   (dec_status),
    .wsel_o     (dec_wsel)
  );

  aux_attempt_ctr #(.MAX_TRIES(MAX_TRIES)) u_try (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_IDLE),
    .inc_i  (state_q == S_ISSUE),
    .last_o (last_try)
  );

  assign wait_load = (state_q == S_RESP) && xfer_done_i &&
                     (dec_act == ACT_WAIT) && !last_try;

  aux_defer_timer #(
    .NAT_US(NAT_US), .I2C_NAT_US(I2C_NAT_US), .I2C_US(I2C_US)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wait_load),
    .sel_i     (dec_wsel),
    .tick_i    (tick_us_i),
    .running_o (wait_run),
    .expire_o  (wait_exp)
  );

  assign active     = state_q != S_IDLE;
  assign xfer_req_o = state_q == S_ISSUE;
  assign done_o     = done_q;
  assign status_o   = status_q;
  assign count_o    = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      mode_q   <= 1'b0;
      size_q   <= '0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      count_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= i2c_mode_i;
          size_q  <= req_size_i;
          state_q <= S_ISSUE;
        end
        S_ISSUE: state_q <= S_RESP;
        S_RESP: if (xfer_done_i) begin
          if (dec_act == ACT_FINISH) begin
            done_q   <= 1'b1;
            status_q <= dec_status;
            count_q  <= (dec_status == ST_OK) ? count_i : '0;
            state_q  <= S_IDLE;
          end else if (last_try) begin
            done_q   <= 1'b1;
            status_q <= ST_EXHAUSTED;
            count_q  <= '0;
            state_q  <= S_IDLE;
          end else begin
            state_q <= (dec_act == ACT_WAIT) ? S_WAIT : S_ISSUE;
          end
        end
        S_WAIT: if (wait_exp) state_q <= S_ISSUE;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

module aux_retry_ctrl_chk #(
  parameter int SIZE_W    = 5,
  parameter int MAX_TRIES = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              active_i,
  input logic              wait_run_i,
  input logic [SIZE_W-1:0] req_size_i,
  input logic              xfer_req_o,
  input logic              done_o,
  input logic [2:0]        status_o,
  input logic [SIZE_W-1:0] count_o
);
  localparam int RW = $clog2(MAX_TRIES + 1) + 1;

  logic [RW-1:0]     req_cnt;
  logic [SIZE_W-1:0] size_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cnt <= '0;
      size_q  <= '0;
    end else begin
      if (done_o)          req_cnt <= '0;
      else if (xfer_req_o) req_cnt <= req_cnt + 1'b1;
      if (start_i && !active_i) size_q <= req_size_i;
    end
  end

  assert_req_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |=> !xfer_req_o);
  assert_req_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> active_i);
  assert_done_pulse_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_try_cap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> req_cnt < RW'(MAX_TRIES));
  assert_exhaust_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd4) |-> req_cnt == RW'(MAX_TRIES));
  assert_full_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 3'd0) |-> count_o >= size_q);
  assert_wait_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_run_i |-> !xfer_req_o);
endmodule

bind aux_retry_ctrl aux_retry_ctrl_chk #(.SIZE_W(SIZE_W), .MAX_TRIES(MAX_TRIES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .active_i   (active),
  .wait_run_i (wait_run),
  .req_size_i (req_size_i),
  .xfer_req_o (xfer_req_o),
  .done_o     (done_o),
  .status_o   (status_o),
  .count_o    (count_o)
);

// File: tb/test_aux_retry_ctrl.sv
module test_aux_retry_ctrl;
  localparam int SW = 5;
  localparam int MAXT = 7;
  localparam int OK = 0, NACK = 1, SHORT = 2, INV = 3, EXH = 4, XERR = 5;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, i2c_mode_i = 0, tick_us_i = 0;
  logic [SW-1:0] req_size_i = '0, count_i = '0;
  logic xfer_done_i = 0;
  logic [1:0] xfer_err_i = '0;
  logic [3:0] reply_i = '0;
  logic xfer_req_o, done_o;
  logic [2:0] status_o;
  logic [SW-1:0] count_o;

  int n_run = 0, n_fail = 0;
  logic [1:0]    r_err [8];
  logic [3:0]    r_rep [8];
  logic [SW-1:0] r_cnt [8];
  int gap_t [8];
  int gap_c [8];
  int n_req;
  int got_status, got_count;
  int again_start;

  always #5 clk = ~clk;

  aux_retry_ctrl i_aux_retry_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .i2c_mode_i(i2c_mode_i),
    .req_size_i(req_size_i), .tick_us_i(tick_us_i), .xfer_req_o(xfer_req_o),
    .xfer_done_i(xfer_done_i), .xfer_err_i(xfer_err_i), .reply_i(reply_i),
    .count_i(count_i), .done_o(done_o), .status_o(status_o), .count_o(count_o)
  );

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk);
      #1;
      ph = (ph + 1) % 3;
      tick_us_i = (ph == 0);
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not end, act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic fill(input logic [1:0] e, input logic [3:0] r, input int c);
    for (int i = 0; i < 8; i++) begin
      r_err[i] = e; r_rep[i] = r; r_cnt[i] = SW'(c);
    end
  endtask

  task automatic run_req(input logic mode, input int size);
    int ticks, cyc, idx, busy_done;
    @(negedge clk);
    start_i = 1; i2c_mode_i = mode; req_size_i = SW'(size);
    @(negedge clk);
    start_i = 0;
    n_req = 0; busy_done = 0; ticks = 0; cyc = 0;
    while (!busy_done) begin
      if (xfer_req_o) begin
        idx = (n_req > 7) ? 7 : n_req;
        gap_t[idx] = ticks; gap_c[idx] = cyc;
        n_req++;
        @(negedge clk);
        if (again_start != 0) begin
          start_i = 1; i2c_mode_i = ~mode; req_size_i = '0;
        end
        @(negedge clk);
        start_i = 0;
        xfer_done_i = 1; xfer_err_i = r_err[idx]; reply_i = r_rep[idx]; count_i = r_cnt[idx];
        @(negedge clk);
        xfer_done_i = 0;
        ticks = 0; cyc = 0;
      end else if (done_o) begin
        got_status = int'(status_o); got_count = int'(count_o);
        busy_done = 1;
        @(negedge clk);
        check(!done_o, "R13 done pulse one cycle", int'(done_o), 0);
      end else begin
        @(negedge clk);
        cyc++;
        if (tick_us_i) ticks++;
      end
    end
  endtask

  initial begin
    again_start = 0;
    repeat (3) @(negedge clk);
    check(!done_o && !xfer_req_o, "R1 reset outputs", int'({done_o, xfer_req_o}), 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    check(!xfer_req_o, "R1 idle without start", int'(xfer_req_o), 0);

    // R6 / R10: size vs count sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 8; s++)
        for (int c = 0; c < 8; c++) begin
          fill(2'b00, 4'b0000, c);
          run_req(m[0], s);
          check(got_status == ((c < s) ? SHORT : OK), m ? "R10 i2c ack count" : "R6 native ack count",
                got_status, (c < s) ? SHORT : OK);
          if (c >= s) check(got_count == c, "R6 count_o", got_count, c);
          check(n_req == 1, "R13 one attempt", n_req, 1);
        end

    // R6: I2C field ignored in native mode
    fill(2'b00, 4'b0100, 3); run_req(0, 3);
    check(got_status == OK, "R6 i2c field ignored native", got_status, OK);
    fill(2'b00, 4'b1100, 3); run_req(0, 3);
    check(got_status == OK, "R6 i2c field 11 ignored native", got_status, OK);

    // R5
    for (int m = 0; m < 2; m++) begin
      fill(2'b00, 4'b0001, 4); run_req(m[0], 4);
      check(got_status == NACK, "R5 native nack", got_status, NACK);
      check(n_req == 1, "R5 no retry", n_req, 1);
    end

    // R4
    for (int e = 2; e < 4; e++) begin
      fill(e[1:0], 4'b0000, 4); run_req(1, 4);
      check(got_status == XERR, "R4 transfer error", got_status, XERR);
      check(n_req == 1, "R4 no retry", n_req, 1);
    end

    // R3 / R12: k leading busy replies
    for (int k = 0; k <= 8; k++) begin
      fill(2'b00, 4'b0000, 2);
      for (int i = 0; i < k && i < 8; i++) r_err[i] = 2'b01;
      run_req(0, 2);
      check(got_status == ((k < MAXT) ? OK : EXH), "R12 busy cap", got_status, (k < MAXT) ? OK : EXH);
      check(n_req == ((k < MAXT) ? k + 1 : MAXT), "R12 attempts", n_req, (k < MAXT) ? k + 1 : MAXT);
      if (k > 0) check(gap_c[1] <= 1, "R3 busy retry without wait", gap_c[1], 0);
    end

    // R7
    fill(2'b00, 4'b0000, 1); r_rep[0] = 4'b0010; run_req(0, 1);
    check(got_status == OK && n_req == 2, "R7 native defer then ok", got_status, OK);
    check(gap_t[1] >= 399 && gap_t[1] <= 401, "R7 native defer wait", gap_t[1], 400);

    // R8
    fill(2'b00, 4'b0000, 1); r_rep[0] = 4'b0010; run_req(1, 1);
    check(got_status == OK && n_req == 2, "R8 i2c native defer then ok", got_status, OK);
    check(gap_t[1] >= 499 && gap_t[1] <= 501, "R8 i2c native defer wait", gap_t[1], 500);

    // R11
    fill(2'b00, 4'b0000, 1); r_rep[0] = 4'b1000; run_req(1, 1);
    check(got_status == OK && n_req == 2, "R11 i2c defer then ok", got_status, OK);
    check(gap_t[1] >= 399 && gap_t[1] <= 401, "R11 i2c defer wait", gap_t[1], 400);
    fill(2'b00, 4'b1100, 1); run_req(1, 1);
    check(got_status == INV, "R11 i2c code 11 invalid", got_status, INV);

    // R10
    fill(2'b00, 4'b0100, 1); run_req(1, 1);
    check(got_status == NACK, "R10 i2c nack", got_status, NACK);

    // R9
    for (int m = 0; m < 2; m++) begin
      fill(2'b00, 4'b0011, 1); run_req(m[0], 1);
      check(got_status == INV, "R9 native code 11", got_status, INV);
    end

    // R12: persistent defer
    fill(2'b00, 4'b1000, 1); run_req(1, 1);
    check(got_status == EXH, "R12 defer exhausted", got_status, EXH);
    check(n_req == MAXT, "R12 defer attempts", n_req, MAXT);

    // R2: restart while active ignored (would flip mode to native and size 0)
    again_start = 1;
    fill(2'b00, 4'b0100, 0); run_req(1, 2);
    again_start = 0;
    check(n_req == 1, "R2 restart ignored attempts", n_req, 1);
    check(got_status == NACK, "R2 restart kept mode", got_status, NACK);
    repeat (5) begin
      @(negedge clk);
      check(!xfer_req_o, "R2 no stray attempt", int'(xfer_req_o), 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule